// File: doc/BRIEF.md
# Timed Tag Response Modulator

This block sends the reply of a contactless tag back to the reader. It switches a single modulate output that gates an external subcarrier. All timing is counted in ticks of a shared timestamp counter, and every reply is placed relative to the frame-end timestamp handed over by the receive side. The arrival time of the request does not set the start of the reply. A data reply carries up to 12 bits. Each bit is masked with a keystream bit supplied from outside, and the keystream is told to advance through a strobe.

A second kind of request sends the write acknowledge. This is a single unmasked one that comes after a much longer gap. When a reply finishes, the block returns the new frame-end timestamp for the receiver to pick up. It also gives a one-cycle done pulse.

Top module: `tag_reply_tx`

## Requirements
- R1: A data reply places its first bit slot at `ts_in + 70` ticks, and each later slot starts 21 ticks after the one before it. Slot boundaries are judged against `now_ts` with wrap-safe arithmetic.
- R2: Data bits go out least significant bit first. During slot i, `mod_out` carries `data_word[i] XOR ks_bit`, so it is high for a masked 1 and low for a masked 0. `ks_bit` is sampled after every advance that comes before that slot.
- R3: A data reply of n bits pulses `ks_adv` exactly n + 2 times. Two pulses come during the gap, before the first bit. One more comes at the end of every bit slot.
- R4: `mod_out` is held through the whole frame and not returned low between bits. It goes low when the final slot ends and stays low whenever the block is idle.
- R5: An acknowledge request sends one bit slot at `ts_in + 758` ticks with `mod_out` high, whatever `ks_bit` is. It pulses `ks_adv` 35 times before the slot and once after it, 36 in all.
- R6: When a reply ends, `ts_out` becomes `ts_in + gap + 21 * bits`, where gap is 70 for data and 758 for an acknowledge. `done` pulses for one cycle, visible right after the clock edge at which `now_ts` equals that value. `ts_out` does not change at any other time.
- R7: `busy` is high from the cycle after an accepted request until the cycle in which `done` pulses. Any request made while `busy` is high is ignored.
- R8: If `req_data` and `req_ack` are high in the same idle cycle, the data reply is taken.
- R9: A `data_len` of 0 sends no bit slot: the reply is the 70-tick gap with two keystream advances, and `ts_out = ts_in + 70`. A length above 12 is treated as 12.
- R10: If `ts_in + gap` already lies in the past, the block still walks every slot from the stored timestamp. It catches up without skipping any bit, so `ts_out` and the advance count are the same as for an on-time start.
- R11: While `rst_n` is low at a clock edge, `mod_out`, `busy`, `done` and `ks_adv` go low and `ts_out` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| now_ts | input | 16 | Shared free-running tick timestamp |
| ts_in | input | 16 | Frame-end timestamp of the preceding frame |
| req_data | input | 1 | Start a data reply (one cycle) |
| data_word | input | 12 | Reply bits, bit 0 sent first |
| data_len | input | 4 | Number of bits to send, 0..12 (larger values clamp to 12) |
| req_ack | input | 1 | Start an acknowledge reply (one cycle) |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Advance the keystream by one step this cycle |
| mod_out | output | 1 | Subcarrier modulate enable |
| busy | output | 1 | A reply is in progress |
| done | output | 1 | One-cycle pulse when a reply ends |
| ts_out | output | 16 | Frame-end timestamp after the last reply |

## Verification
The bench models a keystream register that steps on every `ks_adv`. At mid-slot it samples `mod_out` for each bit of several word patterns. A design that sent the most significant bit first, masked with a keystream that had not yet advanced, or dropped the gap advances would give the wrong level there. The bench also counts the advances and checks the exact `now_ts` at which `done` rises. This catches a gap of 71 instead of 70, a missing step after the acknowledge bit, and a slot of the wrong length.

Directed cases cover the rest. A zero-length request and an over-length request check the clamping. A start timestamp far in the past must still produce the full slot count and the correct `ts_out`. Two requests in the same cycle must give priority to data. An acknowledge sent in the middle of a reply must neither restart nor extend it.

// File: rtl/tagtx_pkg.sv
// Package: shared types of the tag reply modulator.
// Assumes: only the modulator and its checker import it.
package tagtx_pkg;

    // Controller phases of one reply
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_GAP  = 2'd1,   // waiting for the first slot, draining gap advances
        ST_LOAD = 2'd2,   // driving the next bit onto the modulate output
        ST_SLOT = 2'd3    // holding a bit until its slot ends
    } tx_state_e;

endpackage

// File: rtl/tagtx_slot_timer.sv
// Module: slot deadline register.
// Holds the tick deadline of the current phase and flags when the shared
// timestamp has reached it. Compares through a modular difference, so it
// assumes deadlines are never more than half the timestamp range away.
module tagtx_slot_timer #(
    parameter int TS_W       = 16,
    parameter int SLOT_TICKS = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [TS_W-1:0] load_val,
    input  logic            step_en,
    input  logic [TS_W-1:0] now_ts,
    output logic [TS_W-1:0] deadline,
    output logic            reached
);

    localparam logic [TS_W-1:0] SLOT_STEP = TS_W'(SLOT_TICKS);

    logic [TS_W-1:0] diff;

    // Deadline: loaded at the start of a reply, stepped by one slot per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadline <= '0;
        end else if (load_en) begin
            deadline <= load_val;
        end else if (step_en) begin
            deadline <= deadline + SLOT_STEP;
        end
    end

    // Reached when now_ts - deadline is not negative (wrap-safe)
    always_comb begin
        diff    = now_ts - deadline;
        reached = ~diff[TS_W-1];
    end

endmodule

// File: rtl/tagtx_adv_counter.sv
// Module: pending keystream advance counter.
// Loaded with the number of advances that belong to the response gap and
// counted down by one for each strobe the controller issues. Assumes the
// controller only takes a step while pending is high.
module tagtx_adv_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             take,
    output logic             pending
);

    logic [CNT_W-1:0] count;

    // Remaining gap advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (take && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Nonzero flag for the controller
    assign pending = (count != '0);

endmodule

// File: rtl/tagtx_bit_shifter.sv
// Module: reply bit shifter.
// Holds the outgoing word and the count of bits left. Bit 0 leaves first.
// A requested length larger than the word width is clamped to the width.
module tagtx_bit_shifter #(
    parameter int MAX_BITS = 12,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [MAX_BITS-1:0] load_word,
    input  logic [LEN_W-1:0]    load_len,
    input  logic                shift_en,
    output logic                cur_bit,
    output logic                last_bit,
    output logic                empty
);

    localparam int CW = $clog2(MAX_BITS + 1);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BITS);

    logic [MAX_BITS-1:0] word;
    logic [CW-1:0]       left;
    logic [LEN_W-1:0]    len_clamped;

    // Length clamp to the word width
    always_comb begin
        len_clamped = (load_len > LEN_CAP) ? LEN_CAP : load_len;
    end

    // Word and remaining-bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            left <= '0;
        end else if (load_en) begin
            word <= load_word;
            left <= CW'(len_clamped);
        end else if (shift_en && (left != '0)) begin
            word <= word >> 1;
            left <= left - 1'b1;
        end
    end

    // Status towards the controller
    assign cur_bit  = word[0];
    assign last_bit = (left == CW'(1));
    assign empty    = (left == '0);

endmodule

// File: rtl/tag_reply_tx.sv
// Module: timed tag response modulator (top).
// Accepts a data reply or an acknowledge request while idle. It waits until
// the shared timestamp reaches the start of the first slot, drives one bit per
// slot on mod_out, strobes ks_adv for every gap step and every slot, and
// reports the new frame-end timestamp with a one-cycle done.
// Assumes ks_bit reflects an advance by the clock edge after ks_adv is high,
// and that now_ts counts ticks monotonically.
module tag_reply_tx #(
    parameter int TS_W       = 16,
    parameter int MAX_BITS   = 12,
    parameter int LEN_W      = 4,
    parameter int GAP_DATA   = 70,
    parameter int GAP_ACK    = 758,
    parameter int SLOT_TICKS = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     now_ts,
    input  logic [TS_W-1:0]     ts_in,
    input  logic                req_data,
    input  logic [MAX_BITS-1:0] data_word,
    input  logic [LEN_W-1:0]    data_len,
    input  logic                req_ack,
    input  logic                ks_bit,
    output logic                ks_adv,
    output logic                mod_out,
    output logic                busy,
    output logic                done,
    output logic [TS_W-1:0]     ts_out
);

    import tagtx_pkg::*;

    localparam int ADV_DATA = GAP_DATA / SLOT_TICKS - 1;
    localparam int ADV_ACK  = GAP_ACK / SLOT_TICKS - 1;
    localparam int ADV_W    = $clog2(ADV_ACK + 1);
    localparam logic [TS_W-1:0]     GAP_D_T = TS_W'(GAP_DATA);
    localparam logic [TS_W-1:0]     GAP_A_T = TS_W'(GAP_ACK);
    localparam logic [MAX_BITS-1:0] ACK_WORD = MAX_BITS'(1);
    localparam logic [LEN_W-1:0]    ACK_LEN  = LEN_W'(1);

    tx_state_e state;

    logic            accept_data;
    logic            accept_ack;
    logic            accept;
    logic            ack_mode;
    logic [TS_W-1:0] start_ts;
    logic [ADV_W-1:0] adv_load;
    logic [MAX_BITS-1:0] word_load;
    logic [LEN_W-1:0] len_load;
    logic            pend;
    logic            reached;
    logic [TS_W-1:0] deadline;
    logic            cur_bit;
    logic            last_bit;
    logic            empty;
    logic            gap_drain;
    logic            gap_exit;
    logic            slot_end;
    logic            finish;

    // Request decode: data wins over acknowledge, both ignored unless idle
    always_comb begin
        accept_data = (state == ST_IDLE) && req_data;
        accept_ack  = (state == ST_IDLE) && req_ack && !req_data;
        accept      = accept_data || accept_ack;
        start_ts    = ts_in + (accept_data ? GAP_D_T : GAP_A_T);
        adv_load    = accept_data ? ADV_W'(ADV_DATA) : ADV_W'(ADV_ACK);
        word_load   = accept_data ? data_word : ACK_WORD;
        len_load    = accept_data ? data_len : ACK_LEN;
    end

    // Phase events derived from the current state and the helpers
    always_comb begin
        gap_drain = (state == ST_GAP) && pend;
        gap_exit  = (state == ST_GAP) && !pend && reached;
        slot_end  = (state == ST_SLOT) && reached;
        finish    = (gap_exit && empty) || (slot_end && last_bit);
        ks_adv    = gap_drain || slot_end;
        busy      = (state != ST_IDLE);
    end

    tagtx_slot_timer #(
        .TS_W       (TS_W),
        .SLOT_TICKS (SLOT_TICKS)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (accept),
        .load_val (start_ts),
        .step_en  (state == ST_LOAD),
        .now_ts   (now_ts),
        .deadline (deadline),
        .reached  (reached)
    );

    tagtx_adv_counter #(
        .CNT_W (ADV_W)
    ) i_adv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (accept),
        .load_val (adv_load),
        .take     (gap_drain),
        .pending  (pend)
    );

    tagtx_bit_shifter #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept),
        .load_word (word_load),
        .load_len  (len_load),
        .shift_en  (slot_end),
        .cur_bit   (cur_bit),
        .last_bit  (last_bit),
        .empty     (empty)
    );

    // Phase sequencing of one reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) state <= ST_GAP;
                ST_GAP:  if (gap_exit) state <= empty ? ST_IDLE : ST_LOAD;
                ST_LOAD: state <= ST_SLOT;
                ST_SLOT: if (slot_end) state <= last_bit ? ST_IDLE : ST_LOAD;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Reply kind latched at acceptance (acknowledge is never masked)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_mode <= 1'b0;
        end else if (accept) begin
            ack_mode <= accept_ack;
        end
    end

    // Modulate output: set per slot, held between bits, cleared at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_out <= 1'b0;
        end else if (state == ST_LOAD) begin
            mod_out <= ack_mode ? 1'b1 : (cur_bit ^ ks_bit);
        end else if (finish) begin
            mod_out <= 1'b0;
        end
    end

    // Completion pulse and frame-end timestamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            ts_out <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                ts_out <= deadline;
            end
        end
    end

endmodule

// File: rtl/tagtx_checker.sv
// Module: protocol checker for the tag reply modulator, bound to the top.
// Assumes the same synchronous active-low reset as the design.
module tagtx_checker #(
    parameter int TS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_data,
    input logic            req_ack,
    input logic            ks_adv,
    input logic            mod_out,
    input logic            busy,
    input logic            done,
    input logic [TS_W-1:0] ts_out
);

    // Modulate output stays low while idle
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mod_out);

    // Keystream strobes only inside a reply
    assert_adv_in_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |-> busy);

    // Done is a single-cycle pulse
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Frame-end timestamp changes only together with done
    assert_ts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ts_out));

    // Busy has dropped when done pulses, and it was high before
    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // Busy only starts after a request
    assert_busy_from_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_data || req_ack));

endmodule

bind tag_reply_tx tagtx_checker #(.TS_W(TS_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_data (req_data),
    .req_ack  (req_ack),
    .ks_adv   (ks_adv),
    .mod_out  (mod_out),
    .busy     (busy),
    .done     (done),
    .ts_out   (ts_out)
);

// File: tb/test_tag_reply_tx.sv
// Bench: table-driven replies, then directed corner cases.
module test_tag_reply_tx;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 6;
    // {is_ack, len[3:0], word[11:0]}
    localparam logic [16:0] VEC [N_VEC] = '{
        {1'b0, 4'd12, 12'hA5C},
        {1'b0, 4'd1,  12'h001},
        {1'b0, 4'd6,  12'h00D},
        {1'b0, 4'd12, 12'hFFF},
        {1'b0, 4'd7,  12'h000},
        {1'b1, 4'd0,  12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] now_ts = '0;
    logic [15:0] ts_in = '0;
    logic        req_data = 1'b0;
    logic [11:0] data_word = '0;
    logic [3:0]  data_len = '0;
    logic        req_ack = 1'b0;
    logic        ks_bit;
    logic        ks_adv;
    logic        mod_out;
    logic        busy;
    logic        done;
    logic [15:0] ts_out;

    logic [15:0] lfsr = 16'hACE1;
    int          ks_total = 0;
    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;

    tag_reply_tx i_tag_reply_tx (
        .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .ts_in(ts_in),
        .req_data(req_data), .data_word(data_word), .data_len(data_len),
        .req_ack(req_ack), .ks_bit(ks_bit), .ks_adv(ks_adv),
        .mod_out(mod_out), .busy(busy), .done(done), .ts_out(ts_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic ks_after(input logic [15:0] s, input int n);
        logic [15:0] t = s;
        for (int k = 0; k < n; k++) t = lfsr_step(t);
        return t[0];
    endfunction

    // Free-running tick timestamp and keystream model
    always @(posedge clk) begin
        now_ts <= now_ts + 16'd1;
        cycles <= cycles + 1;
        if (ks_adv) begin
            lfsr     <= lfsr_step(lfsr);
            ks_total <= ks_total + 1;
        end
    end
    assign ks_bit = lfsr[0];

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One reply: optional mid-reply poke (R7), both requests (R8), late start (R10)
    task automatic run_xfer(input logic is_ack, input logic [11:0] word,
                            input logic [3:0] len, input int ts_back,
                            input logic timed, input logic poke,
                            input logic both, input string tag);
        logic [15:0] base, ks0, endt;
        int nb, gap, kst0, wait_n;
        logic exp_bit;
        @(negedge clk);
        base = now_ts - 16'(ts_back);
        ks0  = lfsr;
        kst0 = ks_total;
        nb   = is_ack ? 1 : ((len > 4'd12) ? 12 : int'(len));
        gap  = is_ack ? 758 : 70;
        endt = base + 16'(gap + 21 * nb);
        ts_in     = base;
        data_word = word;
        data_len  = len;
        req_data  = !is_ack;
        req_ack   = is_ack || both;
        @(negedge clk);
        req_data = 1'b0;
        req_ack  = 1'b0;
        check(busy == 1'b1, {tag, " R7 busy after request"}, busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            ts_in     = now_ts;
            data_word = 12'hFFF;
            data_len  = 4'd12;
            req_ack   = 1'b1;
            req_data  = 1'b1;
            @(negedge clk);
            req_ack  = 1'b0;
            req_data = 1'b0;
        end
        if (timed) begin
            for (int i = 0; i < nb; i++) begin
                while (now_ts != base + 16'(gap + 21 * i + 10)) @(negedge clk);
                exp_bit = is_ack ? 1'b1 : (word[i] ^ ks_after(ks0, 2 + i));
                check(mod_out == exp_bit,
                      $sformatf("%s R2 R5 bit %0d level", tag, i), mod_out, exp_bit);
            end
        end
        wait_n = 0;
        while (!done && wait_n < 3000) begin
            @(negedge clk);
            wait_n++;
        end
        check(done == 1'b1, {tag, " R6 done seen"}, done, 1);
        if (timed)
            check(now_ts == endt + 16'd1, {tag, " R1 R6 done timing"}, now_ts, endt + 16'd1);
        check(ts_out == endt, {tag, " R6 R10 ts_out"}, ts_out, endt);
        check(mod_out == 1'b0, {tag, " R4 low after frame"}, mod_out, 0);
        check(busy == 1'b0, {tag, " R7 busy low at done"}, busy, 0);
        check(ks_total - kst0 == (is_ack ? 36 : nb + 2),
              {tag, " R3 R5 advance count"}, ks_total - kst0, is_ack ? 36 : nb + 2);
        repeat (30) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, {tag, " R7 stays idle"}, busy, 0);
    endtask

    initial begin
        data_len = 4'd0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(mod_out == 1'b0, "R11 mod_out in reset", mod_out, 0);
        check(busy == 1'b0, "R11 busy in reset", busy, 0);
        check(done == 1'b0, "R11 done in reset", done, 0);
        check(ks_adv == 1'b0, "R11 ks_adv in reset", ks_adv, 0);
        check(ts_out == 16'd0, "R11 ts_out in reset", ts_out, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mod_out == 1'b0 && busy == 1'b0, "R4 idle after reset", mod_out, 0);

        // Table walk: data patterns and an acknowledge
        for (int v = 0; v < N_VEC; v++) begin
            run_xfer(VEC[v][16], VEC[v][11:0], VEC[v][15:12], 0, 1'b1, 1'b0, 1'b0,
                     $sformatf("vec%0d", v));
        end

        // R7 request during a reply is ignored
        run_xfer(1'b0, 12'h3C5, 4'd10, 0, 1'b1, 1'b1, 1'b0, "R7 poke");
        // R8 both requests at once: data wins
        run_xfer(1'b0, 12'h2B1, 4'd9, 0, 1'b1, 1'b0, 1'b1, "R8 both");
        // R9 zero length and over-length clamp
        run_xfer(1'b0, 12'hABC, 4'd0, 0, 1'b1, 1'b0, 1'b0, "R9 len0");
        run_xfer(1'b0, 12'h96E, 4'd15, 0, 1'b1, 1'b0, 1'b0, "R9 len15");
        // R10 start timestamp already in the past
        run_xfer(1'b0, 12'h5A5, 4'd12, 400, 1'b0, 1'b0, 1'b0, "R10 late");
        run_xfer(1'b1, 12'h000, 4'd0, 900, 1'b0, 1'b0, 1'b0, "R10 late ack");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule